// File: doc/BRIEF.md
# Descriptor-Driven DMA Address Sequencer

This block is the address and loop engine of one DMA channel. A descriptor is loaded through a one-cycle load strobe. It holds the source and destination start addresses, signed per-access steps, an access size, a byte count per minor loop and a begin iteration count. It also holds signed adjustments that apply when a major loop ends, and power-of-two modulo windows for each side. Each hardware request starts one minor loop. A minor loop is a burst of byte moves over a simple memory port: a byte is read in one cycle and written in the next.

A current iteration counter tracks progress through the major loop. When the last minor loop of a major loop ends, the counter reloads from the begin count. At that point the end-of-loop adjustments are added, the done flag is set, and an interrupt may be raised. The channel can also drop its own request enable, so that it stops taking requests. A window of 2^n bytes turns either address into a circular buffer. This is how a capture source can fill a ring of records with one record per input event.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset, busy, done, irq, req_en, rd_en and wr_en are 0, and cur_saddr, cur_daddr and cur_iter are 0.
- R2: A cfg_load pulse while idle copies the descriptor. It sets cur_saddr and cur_daddr to the start addresses and cur_iter to cfg_biter, sets req_en to 1, and clears done and irq.
- R3: A hw_req sampled while idle with req_en=1 starts a minor loop of cfg_nbytes bytes. Each byte is read with rd_en, and in the following cycle it is written unchanged with wr_en. The memory returns rd_data one cycle after rd_en.
- R4: An access is 2^cfg_size bytes (size 0 = 1 byte, 2 = 4 bytes), taken at consecutive byte addresses. After each access, each address advances by its own signed step (cfg_soff, cfg_doff, two's complement of width AW).
- R5: A modulo value n≠0 keeps the address bits above bit n-1 fixed, so every computed address wraps inside an aligned 2^n-byte window. A value of 0 disables wrapping.
- R6: Each completed minor loop decrements cur_iter. The minor loop that finds cur_iter=1 completes the major loop, and cur_iter then reloads cfg_biter.
- R7: At major-loop completion, cfg_slast is added to the source address and cfg_dlast is added to the destination address. Both adds are plain, with no wrapping.
- R8: Major-loop completion sets done. It also sets irq when cfg_int_major=1.
- R9: With cfg_int_half=1, irq is set when a minor loop leaves cur_iter equal to cfg_biter/2 (rounded down, nonzero).
- R10: With cfg_req_dis=1, major-loop completion clears req_en. While req_en=0, hw_req is ignored: no memory access happens and the addresses stay unchanged.
- R11: A hw_req that arrives during a minor loop is held and served right after that loop. Any number of such requests counts as one.
- R12: A clr_flags pulse clears done and irq. A set done flag does not block a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load descriptor (honoured only when idle) |
| cfg_saddr | input | AW | Source start address |
| cfg_daddr | input | AW | Destination start address |
| cfg_soff | input | AW | Signed source step per access |
| cfg_doff | input | AW | Signed destination step per access |
| cfg_slast | input | AW | Signed source adjustment at major end |
| cfg_dlast | input | AW | Signed destination adjustment at major end |
| cfg_smod | input | MW | Source modulo window exponent, 0 = off |
| cfg_dmod | input | MW | Destination modulo window exponent, 0 = off |
| cfg_size | input | 2 | Access size exponent in bytes |
| cfg_nbytes | input | NW | Bytes per minor loop |
| cfg_biter | input | IW | Begin iteration count |
| cfg_int_major | input | 1 | Interrupt on major completion |
| cfg_int_half | input | 1 | Interrupt at half of the major loop |
| cfg_req_dis | input | 1 | Clear request enable at major completion |
| hw_req | input | 1 | Hardware transfer request |
| clr_flags | input | 1 | Clear done and irq |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | AW | Memory read byte address |
| rd_data | input | 8 | Read data, valid one cycle after rd_en |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | AW | Memory write byte address |
| wr_data | output | 8 | Write data |
| busy | output | 1 | Minor loop in progress |
| req_en | output | 1 | Channel accepts requests |
| done | output | 1 | Major loop completed |
| irq | output | 1 | Interrupt |
| cur_saddr | output | AW | Current source address |
| cur_daddr | output | AW | Current destination address |
| cur_iter | output | IW | Current iteration count |

## Verification
A request sampled at a clock edge raises busy after that edge. A minor loop then takes two cycles per byte. busy falls at the same edge that writes the final addresses, cur_iter, done, irq and req_en. The bench drives every input at falling edges. After each request it polls busy at falling edges and compares all results once busy is low. Memory contents are compared against a shadow copy that a bench model updates byte by byte in the order the requirements give. A request with nothing to do leaves busy low, so the same check then confirms that nothing moved.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RD   = 2'd1,
    SQ_WR   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/dma_mod_adder.sv
module dma_mod_adder #(
  parameter int AW = 16,
  parameter int MW = 5
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] delta,
  input  logic [MW-1:0] modn,
  output logic [AW-1:0] result
);
  logic [AW-1:0] sum;
  logic [AW-1:0] keep_mask;

  always_comb begin
    sum = base + delta;
    if (modn == '0)
      keep_mask = '1;
    else
      keep_mask = (AW'(1) << modn) - AW'(1);
    result = (base & ~keep_mask) | (sum & keep_mask);
  end
endmodule

// File: rtl/dma_iter_ctrl.sv
module dma_iter_ctrl #(
  parameter int IW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [IW-1:0] biter_in,
  input  logic          int_major_in,
  input  logic          int_half_in,
  input  logic          req_dis_in,
  input  logic          minor_done,
  input  logic          clr,
  output logic [IW-1:0] citer,
  output logic          major_now,
  output logic          stop_now,
  output logic          req_en,
  output logic          done,
  output logic          irq
);
  logic [IW-1:0] biter_q;
  logic          im_q, ih_q, rd_q;
  logic [IW-1:0] citer_dec;

  assign citer_dec = citer - IW'(1);
  assign major_now = minor_done && (citer <= IW'(1));
  assign stop_now  = major_now && rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      biter_q <= '0;
      im_q    <= 1'b0;
      ih_q    <= 1'b0;
      rd_q    <= 1'b0;
      citer   <= '0;
      req_en  <= 1'b0;
      done    <= 1'b0;
      irq     <= 1'b0;
    end else if (load) begin
      biter_q <= biter_in;
      im_q    <= int_major_in;
      ih_q    <= int_half_in;
      rd_q    <= req_dis_in;
      citer   <= biter_in;
      req_en  <= 1'b1;
      done    <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (clr) begin
        done <= 1'b0;
        irq  <= 1'b0;
      end
      if (minor_done) begin
        if (major_now) begin
          citer <= biter_q;
          done  <= 1'b1;
          if (im_q) irq <= 1'b1;
          if (rd_q) req_en <= 1'b0;
        end else begin
          citer <= citer_dec;
          if (ih_q && (citer_dec == (biter_q >> 1))) irq <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int MW = 5,
  parameter int NW = 10,
  parameter int IW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_saddr,
  input  logic [AW-1:0] cfg_daddr,
  input  logic [AW-1:0] cfg_soff,
  input  logic [AW-1:0] cfg_doff,
  input  logic [AW-1:0] cfg_slast,
  input  logic [AW-1:0] cfg_dlast,
  input  logic [MW-1:0] cfg_smod,
  input  logic [MW-1:0] cfg_dmod,
  input  logic [1:0]    cfg_size,
  input  logic [NW-1:0] cfg_nbytes,
  input  logic [IW-1:0] cfg_biter,
  input  logic          cfg_int_major,
  input  logic          cfg_int_half,
  input  logic          cfg_req_dis,
  input  logic          hw_req,
  input  logic          clr_flags,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          busy,
  output logic          req_en,
  output logic          done,
  output logic          irq,
  output logic [AW-1:0] cur_saddr,
  output logic [AW-1:0] cur_daddr,
  output logic [IW-1:0] cur_iter
);
  localparam int BW = 3;

  seq_state_t    st;
  logic [AW-1:0] saddr, daddr;
  logic [AW-1:0] soff_q, doff_q, slast_q, dlast_q;
  logic [MW-1:0] smod_q, dmod_q;
  logic [1:0]    size_q;
  logic [NW-1:0] nbytes_q, bleft;
  logic [BW-1:0] bidx, acc_last;
  logic          pend;

  logic          load_ok, minor_done, major_now, stop_now;
  logic          last_in_acc, last_byte;

  logic [AW-1:0] cur_a  [2];
  logic [AW-1:0] off_a  [2];
  logic [MW-1:0] mod_a  [2];
  logic [AW-1:0] byte_a [2];
  logic [AW-1:0] next_a [2];
  logic [AW-1:0] s_after, d_after;

  assign cur_a[0] = saddr;
  assign cur_a[1] = daddr;
  assign off_a[0] = soff_q;
  assign off_a[1] = doff_q;
  assign mod_a[0] = smod_q;
  assign mod_a[1] = dmod_q;

  for (genvar i = 0; i < 2; i++) begin : g_side
    dma_mod_adder #(.AW(AW), .MW(MW)) u_byte (
      .base(cur_a[i]), .delta(AW'(bidx)), .modn(mod_a[i]), .result(byte_a[i])
    );
    dma_mod_adder #(.AW(AW), .MW(MW)) u_step (
      .base(cur_a[i]), .delta(off_a[i]), .modn(mod_a[i]), .result(next_a[i])
    );
  end

  assign acc_last    = BW'((4'd1 << size_q) - 4'd1);
  assign last_in_acc = (bidx == acc_last);
  assign last_byte   = (bleft == NW'(1));
  assign load_ok     = cfg_load && (st == SQ_IDLE);
  assign minor_done  = (st == SQ_WR) && last_byte;
  assign s_after     = last_in_acc ? next_a[0] : saddr;
  assign d_after     = last_in_acc ? next_a[1] : daddr;

  dma_iter_ctrl #(.IW(IW)) u_iter (
    .clk(clk), .rst(rst), .load(load_ok), .biter_in(cfg_biter),
    .int_major_in(cfg_int_major), .int_half_in(cfg_int_half),
    .req_dis_in(cfg_req_dis), .minor_done(minor_done), .clr(clr_flags),
    .citer(cur_iter), .major_now(major_now), .stop_now(stop_now),
    .req_en(req_en), .done(done), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      saddr    <= '0;
      daddr    <= '0;
      soff_q   <= '0;
      doff_q   <= '0;
      slast_q  <= '0;
      dlast_q  <= '0;
      smod_q   <= '0;
      dmod_q   <= '0;
      size_q   <= '0;
      nbytes_q <= '0;
      bleft    <= '0;
      bidx     <= '0;
      pend     <= 1'b0;
    end else begin
      case (st)
        SQ_IDLE: begin
          pend <= 1'b0;
          if (load_ok) begin
            saddr    <= cfg_saddr;
            daddr    <= cfg_daddr;
            soff_q   <= cfg_soff;
            doff_q   <= cfg_doff;
            slast_q  <= cfg_slast;
            dlast_q  <= cfg_dlast;
            smod_q   <= cfg_smod;
            dmod_q   <= cfg_dmod;
            size_q   <= cfg_size;
            nbytes_q <= cfg_nbytes;
          end else if (hw_req && req_en && (nbytes_q != '0)) begin
            st    <= SQ_RD;
            bleft <= nbytes_q;
            bidx  <= '0;
          end
        end
        SQ_RD: begin
          st <= SQ_WR;
          if (hw_req) pend <= 1'b1;
        end
        default: begin
          bleft <= bleft - NW'(1);
          bidx  <= last_in_acc ? '0 : bidx + BW'(1);
          if (last_byte && major_now) begin
            saddr <= s_after + slast_q;
            daddr <= d_after + dlast_q;
          end else begin
            saddr <= s_after;
            daddr <= d_after;
          end
          if (last_byte) begin
            pend <= 1'b0;
            if ((pend || hw_req) && req_en && !stop_now) begin
              st    <= SQ_RD;
              bleft <= nbytes_q;
              bidx  <= '0;
            end else begin
              st <= SQ_IDLE;
            end
          end else begin
            st <= SQ_RD;
            if (hw_req) pend <= 1'b1;
          end
        end
      endcase
    end
  end

  assign rd_en     = (st == SQ_RD);
  assign rd_addr   = byte_a[0];
  assign wr_en     = (st == SQ_WR);
  assign wr_addr   = byte_a[1];
  assign wr_data   = rd_data;
  assign busy      = (st != SQ_IDLE);
  assign cur_saddr = saddr;
  assign cur_daddr = daddr;
endmodule

// File: rtl/dma_addr_seq_chk.sv
module dma_addr_seq_chk (
  input logic clk,
  input logic rst,
  input logic rd_en,
  input logic wr_en,
  input logic busy,
  input logic req_en,
  input logic done,
  input logic irq,
  input logic clr_flags
);
  // R3
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en));

  // R3
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(rd_en));

  // R10
  req_en_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(req_en) |-> done);

  // R10
  no_access_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_en && !busy) |=> !rd_en);

  // R12
  clr_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_flags && !busy) |=> (!irq && !done));

  // R8
  done_from_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));
endmodule

bind dma_addr_seq dma_addr_seq_chk u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .busy(busy),
  .req_en(req_en), .done(done), .irq(irq), .clr_flags(clr_flags)
);

// File: tb/dma_addr_seq_test.sv
`timescale 1ns/1ps
module dma_addr_seq_test;
  localparam int AW = 8, MW = 5, NW = 10, IW = 9;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_load = 0, cfg_int_major = 0, cfg_int_half = 0, cfg_req_dis = 0;
  logic [AW-1:0] cfg_saddr = 0, cfg_daddr = 0, cfg_soff = 0, cfg_doff = 0;
  logic [AW-1:0] cfg_slast = 0, cfg_dlast = 0;
  logic [MW-1:0] cfg_smod = 0, cfg_dmod = 0;
  logic [1:0] cfg_size = 0;
  logic [NW-1:0] cfg_nbytes = 0;
  logic [IW-1:0] cfg_biter = 0;
  logic hw_req = 0, clr_flags = 0;
  logic rd_en, wr_en, busy, req_en, done, irq;
  logic [AW-1:0] rd_addr, wr_addr, cur_saddr, cur_daddr;
  logic [7:0] rd_data, wr_data;
  logic [IW-1:0] cur_iter;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dma_addr_seq #(.AW(AW), .MW(MW), .NW(NW), .IW(IW)) uut (.*);

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];

  always @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

  // bench model
  logic [7:0] m_s, m_d, d_soff, d_doff, d_slast, d_dlast;
  int m_cit, d_biter, d_smod, d_dmod, d_size, d_nb;
  bit m_en, m_done, m_irq, d_im, d_ih, d_rd;

  function automatic logic [7:0] wrapf(input logic [7:0] b, input logic [7:0] dl, input int n);
    logic [7:0] mk;
    mk = (n == 0) ? 8'hFF : 8'((1 << n) - 1);
    return (b & ~mk) | ((b + dl) & mk);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_minor();
    int asz;
    if (!m_en || d_nb == 0) return;
    asz = 1 << d_size;
    for (int k = 0; k < d_nb; k++) begin
      int bi;
      logic [7:0] ra, wa;
      bi = k % asz;
      ra = wrapf(m_s, 8'(bi), d_smod);
      wa = wrapf(m_d, 8'(bi), d_dmod);
      exp_mem[wa] = exp_mem[ra];
      if (bi == asz - 1) begin
        m_s = wrapf(m_s, d_soff, d_smod);
        m_d = wrapf(m_d, d_doff, d_dmod);
      end
    end
    if (m_cit <= 1) begin
      m_s = m_s + d_slast;
      m_d = m_d + d_dlast;
      m_cit = d_biter;
      m_done = 1;
      if (d_im) m_irq = 1;
      if (d_rd) m_en = 0;
    end else begin
      m_cit--;
      if (d_ih && m_cit == (d_biter >> 1)) m_irq = 1;
    end
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 2000) chk(0, "watchdog", n, 0);
  endtask

  task automatic check_state(input string tag);
    int bad = 0;
    chk(cur_saddr == m_s, {tag, " src addr"}, cur_saddr, m_s);
    chk(cur_daddr == m_d, {tag, " dst addr"}, cur_daddr, m_d);
    chk(cur_iter == IW'(m_cit), {tag, " iter"}, cur_iter, m_cit);
    chk(done == m_done, {tag, " done"}, done, m_done);
    chk(irq == m_irq, {tag, " irq"}, irq, m_irq);
    chk(req_en == m_en, {tag, " req_en"}, req_en, m_en);
    for (int a = 0; a < 256; a++) if (mem[a] !== exp_mem[a]) bad++;
    chk(bad == 0, {tag, " memory"}, bad, 0);
  endtask

  task automatic load(input logic [7:0] s, d, so, dof, sl, dl, input int sm, dm, sz, nb, bi,
                      input bit im, ih, rdis);
    @(negedge clk);
    cfg_saddr = s; cfg_daddr = d; cfg_soff = so; cfg_doff = dof;
    cfg_slast = sl; cfg_dlast = dl; cfg_smod = MW'(sm); cfg_dmod = MW'(dm);
    cfg_size = 2'(sz); cfg_nbytes = NW'(nb); cfg_biter = IW'(bi);
    cfg_int_major = im; cfg_int_half = ih; cfg_req_dis = rdis;
    cfg_load = 1;
    @(negedge clk);
    cfg_load = 0;
    m_s = s; m_d = d; d_soff = so; d_doff = dof; d_slast = sl; d_dlast = dl;
    d_smod = sm; d_dmod = dm; d_size = sz; d_nb = nb; d_biter = bi; m_cit = bi;
    d_im = im; d_ih = ih; d_rd = rdis; m_en = 1; m_done = 0; m_irq = 0;
  endtask

  task automatic one_req();
    @(negedge clk);
    hw_req = 1;
    @(negedge clk);
    hw_req = 0;
    wait_idle();
    model_minor();
  endtask

  task automatic clr();
    @(negedge clk);
    clr_flags = 1;
    @(negedge clk);
    clr_flags = 0;
    m_done = 0; m_irq = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int a = 0; a < 256; a++) begin
      mem[a] = 8'(a * 7 + 3);
      exp_mem[a] = 8'(a * 7 + 3);
    end
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(!busy && !done && !irq && !req_en, "R1 flags", {busy, done, irq, req_en}, 0);
    chk(!rd_en && !wr_en, "R1 strobes", {rd_en, wr_en}, 0);
    chk(cur_saddr == 0 && cur_daddr == 0 && cur_iter == 0, "R1 regs", cur_saddr, 0);
    rst = 0;
    @(negedge clk);
    // R10: request before any load is ignored (req_en=0)
    m_s = 0; m_d = 0; m_cit = 0; m_en = 0; m_done = 0; m_irq = 0; d_nb = 0;
    one_req();
    check_state("R10 before load");

    // R2 load, R3 R4 plain copy, 4-byte accesses
    load(8'h10, 8'h80, 8'd4, 8'd4, 8'hF8, 8'h00, 0, 0, 2, 8, 3, 1, 0, 0);
    check_state("R2 load");
    one_req(); check_state("R3 R4 minor1");
    one_req(); check_state("R6 minor2");
    one_req(); check_state("R7 R8 major");
    // R12: done set does not block the next request
    one_req(); check_state("R12 after done");
    clr(); check_state("R12 clear");

    // R5: destination 8-byte window at aligned base, source step wraps too
    load(8'h40, 8'hA0, 8'd1, 8'd1, 8'h00, 8'h00, 3, 3, 0, 6, 4, 0, 0, 0);
    one_req(); check_state("R5 wrap1");
    one_req(); check_state("R5 wrap2");

    // R9: half interrupt
    load(8'h20, 8'hC0, 8'd1, 8'd2, 8'h00, 8'h00, 0, 5, 0, 2, 4, 0, 1, 0);
    one_req(); check_state("R9 before half");
    one_req(); check_state("R9 at half");

    // R10: request-disable at major end, next request ignored
    load(8'h00, 8'h60, 8'd2, 8'd2, 8'h00, 8'h00, 0, 0, 1, 4, 1, 1, 0, 1);
    one_req(); check_state("R10 major stop");
    one_req(); check_state("R10 ignored");

    // R11: three requests during one loop count as one pending
    load(8'h30, 8'hE0, 8'd1, 8'd1, 8'h00, 8'h00, 0, 4, 0, 4, 8, 0, 0, 0);
    @(negedge clk); hw_req = 1;
    @(negedge clk); hw_req = 1;
    @(negedge clk); hw_req = 1;
    @(negedge clk); hw_req = 0;
    wait_idle();
    model_minor(); model_minor();
    check_state("R11 pending");

    // random descriptors: R3 R4 R5 R6 R7 R8 R9 R10
    for (int t = 0; t < 40; t++) begin
      int sm, dm, sz, nb, bi, sel;
      logic [7:0] s, d, so, dof;
      sm = $urandom_range(0, 5); dm = $urandom_range(0, 5);
      sz = $urandom_range(0, 2);
      nb = $urandom_range(1, 4) << sz;
      bi = $urandom_range(1, 5);
      s = 8'($urandom); d = 8'($urandom);
      if (sm != 0) s = s & ~8'((1 << sm) - 1);
      if (dm != 0) d = d & ~8'((1 << dm) - 1);
      sel = $urandom_range(0, 3);
      so = (sel == 0) ? 8'(1 << sz) : (sel == 1) ? 8'(-(1 << sz)) : (sel == 2) ? 8'h00 : 8'($urandom_range(0, 15));
      sel = $urandom_range(0, 3);
      dof = (sel == 0) ? 8'(1 << sz) : (sel == 1) ? 8'(-(1 << sz)) : (sel == 2) ? 8'h00 : 8'($urandom_range(0, 15));
      load(s, d, so, dof, 8'($urandom), 8'($urandom), sm, dm, sz, nb, bi,
           1'($urandom), 1'($urandom), 1'($urandom));
      for (int r = 0; r <= bi; r++) begin
        one_req();
        check_state("R3 R4 R5 R6 R7 R8 R9 R10 random");
        if ($urandom_range(0, 3) == 0) clr();
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule